// File: doc/BRIEF.md
# Modem Status Change Interrupt Logic

This block watches two active-low handshake inputs from a modem, Clear to Send and Data Set Ready. Each pin goes through a synchronizer. The block then shows both as active-high bits in a status word, so software reads 1 for "asserted" whatever the pin polarity is.

Any level change on either line sets one shared sticky change flag. The flag holds until software pulses a clear strobe. An interrupt line is driven while the flag is set and two enables are both on: a modem-interrupt enable and a global interrupt enable.

Top module: `modem_status_irq`

## Requirements
- R1: `mdm_stat` bit 0 reads 1 when `cts_n` is low and 0 when it is high. It shows the pin level that was sampled two clock edges earlier.
- R2: `mdm_stat` bit 1 reads 1 when `dsr_n` is low and 0 when it is high, with the same two-edge latency as R1.
- R3: `mdm_stat` bits 7 to 2 always read 0.
- R4: A rising or a falling level change on either pin sets `chg_flag` one clock after `mdm_stat` first shows the new level.
- R5: Once set, `chg_flag` stays set until `chg_clr` is sampled high.
- R6: When `chg_clr` is high and no change is detected in the same cycle, `chg_flag` reads 0 after that edge.
- R7: When `chg_clr` is high in the same cycle that a change is detected, `chg_flag` stays (or becomes) 1.
- R8: `irq` is high exactly when `chg_flag`, `mdm_ie` and `glb_ie` are all 1. It follows the enables without delay.
- R9: While `rst_n` is low, `chg_flag` and `irq` go to 0 at the next edge. Pin levels that are held steady through reset do not set `chg_flag` after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cts_n | input | 1 | Clear to Send pin, active low, asynchronous |
| dsr_n | input | 1 | Data Set Ready pin, active low, asynchronous |
| mdm_ie | input | 1 | Modem-interrupt enable |
| glb_ie | input | 1 | Global interrupt enable |
| chg_clr | input | 1 | Clear strobe for the change flag |
| mdm_stat | output | 8 | Status word: bit 0 CTS true, bit 1 DSR true, others 0 |
| chg_flag | output | 1 | Sticky modem-status change flag |
| irq | output | 1 | Interrupt request |

## Verification
A clear strobe and a newly detected line change can land in the same cycle. The correct result is that the flag survives.

The bench provokes this collision on purpose. It changes a pin, waits the two synchronizer edges until the status word shows the new level, and holds `chg_clr` high in exactly that cycle. After the next edge it expects `chg_flag` to be 1. A plain clear, with no change in that cycle, is expected to read 0.

Both pins and every pair of start and end levels are swept under all four enable combinations. For each one, the flag is expected to be set exactly when the levels differ, and `irq` is expected only when the flag is set and both enables are on.

// File: rtl/modem_status_irq.sv
module modem_status_irq #(
  parameter int SYNC_STAGES = 2,
  parameter int STAT_W      = 8,
  parameter int CTS_POS     = 0,
  parameter int DSR_POS     = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cts_n,
  input  logic              dsr_n,
  input  logic              mdm_ie,
  input  logic              glb_ie,
  input  logic              chg_clr,
  output logic [STAT_W-1:0] mdm_stat,
  output logic              chg_flag,
  output logic              irq
);
  localparam int LAST = SYNC_STAGES - 1;

  // bit 0 = CTS, bit 1 = DSR; pin polarity (low = true)
  logic [1:0] sync_q [SYNC_STAGES];
  logic [1:0] prev_q;
  logic [1:0] line_now;
  logic       change;

  always_ff @(posedge clk) begin
    sync_q[0] <= {dsr_n, cts_n};
    for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
  end

  assign line_now = sync_q[LAST];

  // keeps tracking during reset, so levels held through reset are not seen as a change
  always_ff @(posedge clk) prev_q <= line_now;

  assign change = |(line_now ^ prev_q);

  always_ff @(posedge clk) begin
    if (!rst_n) chg_flag <= 1'b0;
    else        chg_flag <= change | (chg_flag & ~chg_clr);
  end

  always_comb begin
    mdm_stat          = '0;
    mdm_stat[CTS_POS] = ~line_now[0];
    mdm_stat[DSR_POS] = ~line_now[1];
  end

  assign irq = chg_flag & mdm_ie & glb_ie;
endmodule

module modem_status_irq_chk #(
  parameter int STAT_W  = 8,
  parameter int CTS_POS = 0,
  parameter int DSR_POS = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cts_n,
  input logic              dsr_n,
  input logic              mdm_ie,
  input logic              glb_ie,
  input logic              chg_clr,
  input logic [STAT_W-1:0] mdm_stat,
  input logic              chg_flag,
  input logic              irq
);
  localparam logic [STAT_W-1:0] USED = (STAT_W'(1) << CTS_POS) | (STAT_W'(1) << DSR_POS);

  assert_cts_image_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mdm_stat[CTS_POS] == !$past(cts_n, 2));
  assert_dsr_image_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mdm_stat[DSR_POS] == !$past(dsr_n, 2));
  assert_unused_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mdm_stat & ~USED) == '0);
  assert_change_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdm_stat) |=> chg_flag);
  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    chg_flag && !chg_clr |=> chg_flag);
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    chg_clr && $stable(mdm_stat) |=> !chg_flag);
  assert_collide_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chg_clr && !$stable(mdm_stat) |=> chg_flag);
  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> chg_flag && mdm_ie && glb_ie);
  assert_irq_fire_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chg_flag && mdm_ie && glb_ie |-> irq);
  assert_reset_R9: assert property (@(posedge clk)
    $rose(rst_n) |-> !chg_flag && !irq);
endmodule

bind modem_status_irq modem_status_irq_chk #(
  .STAT_W(STAT_W), .CTS_POS(CTS_POS), .DSR_POS(DSR_POS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cts_n(cts_n), .dsr_n(dsr_n),
  .mdm_ie(mdm_ie), .glb_ie(glb_ie), .chg_clr(chg_clr),
  .mdm_stat(mdm_stat), .chg_flag(chg_flag), .irq(irq)
);

// File: tb/modem_status_irq_tb.sv
module modem_status_irq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cts_n = 1'b1, dsr_n = 1'b1;
  logic mdm_ie = 1'b0, glb_ie = 1'b0, chg_clr = 1'b0;
  logic [7:0] mdm_stat;
  logic chg_flag, irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  modem_status_irq u_dut (
    .clk(clk), .rst_n(rst_n), .cts_n(cts_n), .dsr_n(dsr_n),
    .mdm_ie(mdm_ie), .glb_ie(glb_ie), .chg_clr(chg_clr),
    .mdm_stat(mdm_stat), .chg_flag(chg_flag), .irq(irq)
  );

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // pins as {dsr_n, cts_n}; expected status = inverted pins in bits 1:0
  function automatic logic [7:0] stat_of(input logic [1:0] pins);
    return {6'b0, ~pins[1], ~pins[0]};
  endfunction

  task automatic set_pins(input logic [1:0] p);
    {dsr_n, cts_n} = p;
  endtask

  task automatic clear_flag();
    chg_clr = 1'b1;
    tick();
    chg_clr = 1'b0;
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R9: pins held active through reset; nothing flagged afterwards
    set_pins(2'b10);
    mdm_ie = 1'b1;
    glb_ie = 1'b1;
    tick(5);
    chk("R9 flag in reset", {7'b0, chg_flag}, 8'h00);
    rst_n = 1'b1;
    tick(4);
    chk("R9 flag after reset", {7'b0, chg_flag}, 8'h00);
    chk("R9 irq after reset", {7'b0, irq}, 8'h00);
    chk("R1 R2 R3 status after reset", mdm_stat, stat_of(2'b10));

    // R1 R2 latency: the new level shows after exactly two edges
    set_pins(2'b01);
    tick();
    chk("R1 R2 one edge: old level", mdm_stat, stat_of(2'b10));
    tick();
    chk("R1 R2 two edges: new level", mdm_stat, stat_of(2'b01));
    chk("R4 not yet set", {7'b0, chg_flag}, 8'h00);
    tick();
    chk("R4 set one edge later", {7'b0, chg_flag}, 8'h01);
    tick(3);
    chk("R5 sticky", {7'b0, chg_flag}, 8'h01);
    clear_flag();
    chk("R6 plain clear", {7'b0, chg_flag}, 8'h00);

    // sweep over start level x end level x enable pair
    for (int from = 0; from < 4; from++)
      for (int to = 0; to < 4; to++)
        for (int en = 0; en < 4; en++) begin
          logic exp_f;
          mdm_ie = 1'b0;
          glb_ie = 1'b0;
          set_pins(2'(from));
          tick(4);
          clear_flag();
          chk("R6 cleared before step", {7'b0, chg_flag}, 8'h00);
          chk("R1 R2 R3 start level", mdm_stat, stat_of(2'(from)));
          {glb_ie, mdm_ie} = 2'(en);
          set_pins(2'(to));
          tick(2);
          chk("R1 R2 R3 end level", mdm_stat, stat_of(2'(to)));
          tick();
          exp_f = (from != to);
          chk("R4 change flag", {7'b0, chg_flag}, {7'b0, exp_f});
          chk("R8 irq", {7'b0, irq}, {7'b0, exp_f && en == 3});
        end

    // R8: irq follows the enables without delay while the flag is set
    set_pins(2'b00);
    tick(3);
    for (int en = 0; en < 4; en++) begin
      {glb_ie, mdm_ie} = 2'(en);
      #1;
      chk("R8 enable follow", {7'b0, irq}, {7'b0, en == 3});
    end

    // R7: clear lands in the same cycle as a newly detected change
    clear_flag();
    chk("R6 clear before collision", {7'b0, chg_flag}, 8'h00);
    set_pins(2'b11);
    tick(2);
    chg_clr = 1'b1;
    tick();
    chg_clr = 1'b0;
    chk("R7 collision from clear", {7'b0, chg_flag}, 8'h01);
    set_pins(2'b10);
    tick(2);
    chg_clr = 1'b1;
    tick();
    chg_clr = 1'b0;
    chk("R7 collision while set", {7'b0, chg_flag}, 8'h01);
    tick();
    chk("R5 held after collision", {7'b0, chg_flag}, 8'h01);

    // R9: reset clears a set flag
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(3);
    chk("R9 flag cleared by reset", {7'b0, chg_flag}, 8'h00);
    chk("R9 irq cleared by reset", {7'b0, irq}, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule